// File: doc/BRIEF.md
# Gray-Level PWM Duty Generator

This block converts a 4-bit gray code per color channel into a pulse-width-modulated drive enable for the segment driver of that channel. Each of the three channels owns a palette of sixteen 5-bit entries, and each entry picks one of 32 duty levels, where a value of v keeps the output on for v of the 31 slots in a line. The palette can be bypassed in two ways: a fixed preset ramp, or a monochrome mode in which every pixel is either fully lit or fully dark.

A register port writes single palette entries and the two mode bits. A pixel port presents one code per channel together with a one-cycle line-start pulse. A slot tick advances a 5-bit slot counter through the 31 slots of the line. The codes, the mode bits and the palette lookup are all captured on line-start, so the line being driven keeps its duty when the palette or the mode is rewritten part way through it.

Top module: `gray_pwm_gen`

## Requirements
- R1: After a synchronous reset, `pwm_en` is 0. For the 16 cycles after reset is released, an internal sweep loads every palette entry of every channel with its preset value (code 0 gives 0 and code c gives 2c+1). Palette writes from the port during that sweep are ignored.
- R2: The slot counter is set to 0 by `line_start`, advances by one on each `slot_tick` cycle, wraps from 30 to 0, and holds when neither input is high.
- R3: In every cycle, `pwm_en[c]` takes the value "slot counter < level of channel c" as it was in the previous cycle. With ticks in every cycle after a line start, slot k (k = 0..30) therefore appears in the k+1-th cycle after the line-start edge.
- R4: With `mode_mono`=0 and `mode_fixed`=0 (variable mode), the level of channel c is its palette entry addressed by its pixel code.
- R5: With `mode_mono`=0 and `mode_fixed`=1, the level is 0 for code 0 and 2*code+1 for any other code, whatever the palette holds.
- R6: With `mode_mono`=1, the level is 31 when bit 3 of the code is 1 and 0 otherwise, whatever `mode_fixed` and the palette hold.
- R7: A palette write with `cfg_we`=1 stores `cfg_level` at entry `cfg_idx` of channel `cfg_ch` only; `cfg_ch` values 0, 1 and 2 select the channels, and the value 3 writes nothing. Channel c reads its code from `pix_code[4c+3:4c]`.
- R8: Pixel codes, mode bits and the palette entry read are captured at the `line_start` edge. A palette write, a mode write or a change of `pix_code` after that edge does not change the outputs of the current line and takes effect from the next `line_start`.
- R9: A level of 31 keeps `pwm_en` high in all 31 slots of the line, and a level of 0 keeps it low in all of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Palette entry write strobe |
| cfg_ch | input | 2 | Channel selected by the write |
| cfg_idx | input | 4 | Palette entry index |
| cfg_level | input | 5 | Duty level to store |
| mode_we | input | 1 | Mode bit write strobe |
| mode_fixed | input | 1 | 1 selects the preset ramp instead of the palette |
| mode_mono | input | 1 | 1 selects on/off display from code bit 3 |
| line_start | input | 1 | One-cycle pulse opening a new line |
| slot_tick | input | 1 | Advance the slot counter by one |
| pix_code | input | 12 | Gray codes, channel c in bits 4c+3..4c |
| pwm_en | output | 3 | Drive enable per channel |

## Verification
Every result is due one cycle behind the state that produces it: the line-start edge loads counter, codes, mode and palette read, and the enable for slot k is registered at the edge of the k-th tick after it, so the bench samples each output at the falling edge that follows that tick. The wrap back to slot 0 shows one cycle after the last tick even without another tick, and a held counter keeps the enable fixed for every idle cycle, both sampled the same way. Writes made during a line are sampled against the old level for the rest of that line and against the new one from the next line-start onward. Preset, monochrome and variable palettes are swept over all sixteen codes, with different codes on the three channels.

// File: rtl/gpw_pkg.sv
`timescale 1ns/1ps
package gpw_pkg;

  // Mode bits as held in the register and per line
  typedef struct packed {
    logic fixed;
    logic mono;
  } gpw_mode_t;

  // Source of the level chosen for a channel
  typedef enum logic [1:0] {
    SRC_PALETTE = 2'd0,
    SRC_PRESET  = 2'd1,
    SRC_MONO    = 2'd2
  } gpw_src_e;

  function automatic gpw_src_e pick_src(gpw_mode_t m);
    if (m.mono)       return SRC_MONO;
    else if (m.fixed) return SRC_PRESET;
    else              return SRC_PALETTE;
  endfunction

endpackage

// File: rtl/gpw_slot_counter.sv
`timescale 1ns/1ps
module gpw_slot_counter #(
  parameter int CNT_W = 5,
  parameter int NSLOT = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             slot_tick,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NSLOT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (line_start) begin
      cnt <= '0;
    end else if (slot_tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/gpw_palette_init.sv
`timescale 1ns/1ps
module gpw_palette_init #(
  parameter int CODE_W = 4,
  localparam int LVL_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              busy,
  output logic [CODE_W-1:0] idx,
  output logic [LVL_W-1:0]  lvl
);

  localparam logic [CODE_W-1:0] LAST_IDX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST_IDX) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  // Preset ramp value for the entry being loaded
  always_comb begin
    if (idx == '0) lvl = '0;
    else           lvl = {idx, 1'b1};
  end

endmodule

// File: rtl/gpw_palette_ram.sv
`timescale 1ns/1ps
module gpw_palette_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with a resettable output register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/gpw_level_sel.sv
`timescale 1ns/1ps
module gpw_level_sel #(
  parameter int CODE_W = 4,
  localparam int LVL_W = CODE_W + 1
) (
  input  gpw_pkg::gpw_mode_t mode,
  input  logic [CODE_W-1:0]  code,
  input  logic [LVL_W-1:0]   pal,
  output logic [LVL_W-1:0]   level
);

  import gpw_pkg::*;

  gpw_src_e src;

  always_comb begin
    src = pick_src(mode);
    unique case (src)
      SRC_MONO:   level = code[CODE_W-1] ? '1 : '0;
      SRC_PRESET: level = (code == '0) ? '0 : {code, 1'b1};
      default:    level = pal;
    endcase
  end

endmodule

// File: rtl/gray_pwm_gen.sv
`timescale 1ns/1ps
module gray_pwm_gen #(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 4,
  localparam int LVL_W = CODE_W + 1,
  localparam int NSLOT = (1 << LVL_W) - 1,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CH_W-1:0]          cfg_ch,
  input  logic [CODE_W-1:0]        cfg_idx,
  input  logic [LVL_W-1:0]         cfg_level,
  input  logic                     mode_we,
  input  logic                     mode_fixed,
  input  logic                     mode_mono,
  input  logic                     line_start,
  input  logic                     slot_tick,
  input  logic [NUM_CH*CODE_W-1:0] pix_code,
  output logic [NUM_CH-1:0]        pwm_en
);

  import gpw_pkg::*;

  gpw_mode_t mode_reg;
  gpw_mode_t mode_line;

  logic [LVL_W-1:0]  slot_cnt;
  logic              init_busy;
  logic [CODE_W-1:0] init_idx;
  logic [LVL_W-1:0]  init_lvl;

  logic [CODE_W-1:0] wr_idx;
  logic [LVL_W-1:0]  wr_lvl;

  logic [NUM_CH-1:0][CODE_W-1:0] code_q;
  logic [NUM_CH-1:0][LVL_W-1:0]  rd_lvl;
  logic [NUM_CH-1:0][LVL_W-1:0]  level;
  logic [NUM_CH-1:0]             pwm_next;

  // Mode register, applied per line
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_reg  <= '0;
      mode_line <= '0;
    end else begin
      if (mode_we)    mode_reg  <= '{fixed: mode_fixed, mono: mode_mono};
      if (line_start) mode_line <= mode_reg;
    end
  end

  gpw_slot_counter #(
    .CNT_W (LVL_W),
    .NSLOT (NSLOT)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .slot_tick  (slot_tick),
    .cnt        (slot_cnt)
  );

  gpw_palette_init #(
    .CODE_W (CODE_W)
  ) u_init (
    .clk  (clk),
    .rst  (rst),
    .busy (init_busy),
    .idx  (init_idx),
    .lvl  (init_lvl)
  );

  assign wr_idx = init_busy ? init_idx : cfg_idx;
  assign wr_lvl = init_busy ? init_lvl : cfg_level;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic we_ch;
    assign we_ch = init_busy | (cfg_we && (cfg_ch == CH_W'(ch)));

    gpw_palette_ram #(
      .ADDR_W (CODE_W),
      .DATA_W (LVL_W)
    ) u_ram (
      .clk   (clk),
      .rst   (rst),
      .we    (we_ch),
      .waddr (wr_idx),
      .wdata (wr_lvl),
      .re    (line_start),
      .raddr (pix_code[ch*CODE_W +: CODE_W]),
      .rdata (rd_lvl[ch])
    );

    gpw_level_sel #(
      .CODE_W (CODE_W)
    ) u_sel (
      .mode  (mode_line),
      .code  (code_q[ch]),
      .pal   (rd_lvl[ch]),
      .level (level[ch])
    );

    assign pwm_next[ch] = (slot_cnt < level[ch]);
  end

  // Line capture of the codes and registered enables
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      pwm_en <= '0;
    end else begin
      if (line_start) code_q <= pix_code;
      pwm_en <= pwm_next;
    end
  end

endmodule

// File: rtl/gpw_checker.sv
`timescale 1ns/1ps
module gpw_checker #(
  parameter int NUM_CH = 3,
  parameter int LVL_W  = 5
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          line_start,
  input logic                          slot_tick,
  input logic [LVL_W-1:0]              slot_cnt,
  input logic [NUM_CH-1:0][LVL_W-1:0]  level,
  input logic [NUM_CH-1:0]             pwm_en
);

  localparam logic [LVL_W-1:0] LAST = LVL_W'((1 << LVL_W) - 2);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    slot_cnt <= LAST);

  assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (rst)
    line_start |=> slot_cnt == '0);

  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && !line_start && slot_cnt == LAST) |=> slot_cnt == '0);

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!slot_tick && !line_start) |=> $stable(slot_cnt));

  // Levels of a line only change at a line start
  assert_line_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(level));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_rise
    // An enable can only switch on in the cycle after slot 0
    assert_rise_slot0_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_en[ch]) |-> $past(slot_cnt) == '0);
  end

endmodule

bind gray_pwm_gen gpw_checker #(
  .NUM_CH (NUM_CH),
  .LVL_W  (LVL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_start (line_start),
  .slot_tick  (slot_tick),
  .slot_cnt   (slot_cnt),
  .level      (level),
  .pwm_en     (pwm_en)
);

// File: tb/sim_gray_pwm_gen.sv
`timescale 1ns/1ps
module sim_gray_pwm_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [3:0]  cfg_idx = '0;
  logic [4:0]  cfg_level = '0;
  logic        mode_we = 1'b0;
  logic        mode_fixed = 1'b0;
  logic        mode_mono = 1'b0;
  logic        line_start = 1'b0;
  logic        slot_tick = 1'b0;
  logic [11:0] pix_code = '0;
  logic [2:0]  pwm_en;

  int checks = 0;
  int errors = 0;
  logic [4:0] pal_m [3][16];
  bit m_fixed = 1'b0;
  bit m_mono  = 1'b0;

  always #10 clk = ~clk;

  gray_pwm_gen u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_idx(cfg_idx),
    .cfg_level(cfg_level), .mode_we(mode_we), .mode_fixed(mode_fixed),
    .mode_mono(mode_mono), .line_start(line_start), .slot_tick(slot_tick),
    .pix_code(pix_code), .pwm_en(pwm_en)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_level(int ch, int code);
    if (m_mono)  return (code >= 8) ? 31 : 0;
    if (m_fixed) return (code == 0) ? 0 : 2 * code + 1;
    return int'(pal_m[ch][code]);
  endfunction

  task automatic wr_pal(int ch, int idx, int val, bit upd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_idx = 4'(idx); cfg_level = 5'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (upd && ch < 3) pal_m[ch][idx] = 5'(val);
  endtask

  task automatic set_mode(bit fx, bit mn);
    @(negedge clk);
    mode_we = 1'b1; mode_fixed = fx; mode_mono = mn;
    @(negedge clk);
    mode_we = 1'b0;
    m_fixed = fx; m_mono = mn;
  endtask

  // One line: line-start pulse, 31 ticks, optional stall and mid-line writes
  task automatic run_line(int c0, int c1, int c2, string req, int stall_k, bit mid);
    int lv [3];
    int bad [3];
    int cd [3];
    int nv;
    cd[0] = c0; cd[1] = c1; cd[2] = c2;
    for (int c = 0; c < 3; c++) begin
      lv[c] = exp_level(c, cd[c]);
      bad[c] = 0;
    end
    nv = (int'(pal_m[0][c0]) + 9) % 32;
    @(negedge clk);
    pix_code = {4'(c2), 4'(c1), 4'(c0)};
    line_start = 1'b1; slot_tick = 1'b0;
    @(negedge clk);
    line_start = 1'b0;
    for (int k = 0; k < 31; k++) begin
      if (k == stall_k) begin
        for (int s = 0; s < 3; s++) begin
          slot_tick = 1'b0;
          @(negedge clk);
          for (int c = 0; c < 3; c++)
            if (pwm_en[c] != (k < lv[c])) bad[c]++;
        end
      end
      if (mid && k == 10) begin
        cfg_we = 1'b1; cfg_ch = 2'd0; cfg_idx = 4'(c0); cfg_level = 5'(nv);
        mode_we = 1'b1; mode_fixed = 1'b1; mode_mono = 1'b0;
        pix_code = ~pix_code;
      end
      slot_tick = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; mode_we = 1'b0;
      for (int c = 0; c < 3; c++)
        if (pwm_en[c] != (k < lv[c])) bad[c]++;
    end
    slot_tick = 1'b0;
    for (int c = 0; c < 3; c++)
      check(bad[c] == 0, $sformatf("%s ch%0d code %0d level %0d slot mismatches", req, c, cd[c], lv[c]), bad[c], 0);
    // Counter wrapped to slot 0: enable returns for any nonzero level (R2)
    @(negedge clk);
    for (int c = 0; c < 3; c++)
      check(pwm_en[c] == (lv[c] > 0), $sformatf("R2 wrap ch%0d", c), int'(pwm_en[c]), int'(lv[c] > 0));
    if (mid) begin
      pal_m[0][c0] = 5'(nv);
      m_fixed = 1'b1; m_mono = 1'b0;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired R2 actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 16; i++)
        pal_m[c][i] = (i == 0) ? 5'd0 : 5'(2 * i + 1);
    repeat (3) @(negedge clk);
    check(pwm_en == 3'b000, "R1 enables low in reset", int'(pwm_en), 0);
    rst = 1'b0;
    // Write during the init sweep must be dropped (R1)
    wr_pal(0, 5, 0, 1'b0);
    repeat (20) @(negedge clk);
    check(pwm_en == 3'b000, "R1 enables low after reset", int'(pwm_en), 0);

    // R1 R4: preset contents read through the variable palette
    for (int i = 0; i < 16; i++) run_line(i, i, i, "R1 R4 defaults", -1, 1'b0);

    // R7: program distinct palettes, write to channel 3 is dropped
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 16; i++)
        wr_pal(c, i, (i * 7 + c * 11 + 3) % 32, 1'b1);
    wr_pal(3, 0, 31, 1'b0);
    wr_pal(3, 9, 31, 1'b0);
    for (int i = 0; i < 16; i++)
      run_line(i, (i + 5) % 16, (i + 10) % 16, "R4 R7 variable", -1, 1'b0);

    // R2: counter holds while ticks pause
    run_line(3, 8, 12, "R2 stall", 15, 1'b0);
    run_line(4, 1, 7, "R2 stall at slot 0", 0, 1'b0);

    // R9: full and empty duty
    wr_pal(0, 1, 31, 1'b1);
    wr_pal(1, 1, 0, 1'b1);
    wr_pal(2, 1, 30, 1'b1);
    run_line(1, 1, 1, "R9 extremes", -1, 1'b0);

    // R5: preset ramp ignores the palette
    set_mode(1'b1, 1'b0);
    wr_pal(1, 4, 0, 1'b1);
    for (int i = 0; i < 16; i++)
      run_line(i, (i + 3) % 16, 15 - i, "R5 preset", -1, 1'b0);

    // R6: monochrome, also over the preset bit
    set_mode(1'b0, 1'b1);
    for (int i = 0; i < 16; i++)
      run_line(i, (i + 8) % 16, 15 - i, "R6 mono", -1, 1'b0);
    set_mode(1'b1, 1'b1);
    run_line(8, 7, 0, "R6 mono over preset", -1, 1'b0);

    // R8: mid-line palette, mode and code changes wait for next line
    set_mode(1'b0, 1'b0);
    run_line(2, 6, 9, "R8 mid-line writes", -1, 1'b1);
    check(m_fixed == 1'b1, "R8 model", int'(m_fixed), 1);
    run_line(2, 6, 9, "R8 preset after mid-line mode write", -1, 1'b0);
    set_mode(1'b0, 1'b0);
    run_line(2, 6, 9, "R8 new palette entry", -1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule